// File: doc/BRIEF.md
# Serial Flash Command Engine

This block is the byte-level command front end of a serial NOR flash device model. It sits behind a bit deserializer. That deserializer hands it whole bytes from the controller, each with a one-cycle strobe, together with the current chip-select level. The engine treats the first byte of each selected frame as an opcode and then walks the byte phases of that command. Deselecting the device ends the command; no command has a fixed length.

Two commands are understood. A status read puts the status byte supplied by the array side on the response byte for every byte that follows the opcode, for as long as the frame lasts. A page program takes in a three-byte target address, most significant byte first. It writes each later byte into a one-page buffer through a write port. When the frame ends it raises a one-cycle program request that carries the address and the number of bytes taken. Any other opcode raises an unknown-command pulse.

The byte input works like a stream that has valid and no ready. The controller owns the serial clock, so the engine cannot apply back-pressure. It accepts one byte in any cycle the strobe is high, and strobes may arrive back to back. The buffer write port and the program request are also valid-only pulses, and the consumer must take them in the cycle they appear.

Top module: `spi_flash_cmd_engine`

## Requirements
- R1: After reset, buf_we, prog_req and unknown_cmd are 0 and miso_byte is 0xFF.
- R2: Opcode 0x05 enters status-read. From the next cycle until deselect, miso_byte equals the current status_in, for any number of following bytes.
- R3: Opcode 0x02 enters page-program. The next three bytes form prog_addr, with the first of them as bits 23:16 and the last as bits 7:0.
- R4: Each page-program byte after the address pulses buf_we for exactly one cycle, in the cycle after its strobe. buf_wdata is that byte. buf_waddr is (prog_addr[7:0] + n) mod 256 for the n-th data byte, counting from 0.
- R5: If more than 256 data bytes arrive, buf_waddr wraps within the page and prog_count stops at 256.
- R6: In the cycle after cs_n goes high, prog_req pulses for one cycle with prog_addr and prog_count (the data byte count), but only if all three address bytes and at least one data byte were received.
- R7: A page-program ended during the address phase, or with no data byte, produces no prog_req. The next transaction assembles its address from scratch.
- R8: Any opcode other than 0x05 and 0x02 pulses unknown_cmd in the cycle after its strobe, and the engine returns to idle. The next byte in the same frame is decoded as a new opcode.
- R9: miso_byte is 0xFF while idle and throughout page-program.
- R10: cs_n high returns the engine to idle. Byte strobes that arrive while cs_n is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select level, low = selected |
| rx_valid | input | 1 | One-cycle strobe for a received byte |
| rx_byte | input | 8 | Byte from the controller |
| status_in | input | 8 | Status byte from the array side |
| miso_byte | output | 8 | Response byte for the next byte slot |
| unknown_cmd | output | 1 | Pulse: unsupported opcode seen |
| buf_we | output | 1 | Page buffer write strobe |
| buf_waddr | output | 8 | Page buffer write index |
| buf_wdata | output | 8 | Page buffer write data |
| prog_req | output | 1 | Pulse: program the buffered page |
| prog_addr | output | 24 | Target address of the program |
| prog_count | output | 9 | Number of data bytes received (1..256) |

## Verification
Every one of the 256 opcode values is sent as the first byte of a frame. This separates the two supported opcodes from the unknown ones and checks the response byte that each selects. Status reads are repeated within one frame while the status input changes, so a response that is stale or taken only once would show. Page programs are run with lengths of 0, 1, 2, 255, 256, 257 and 300 and with addresses whose low byte varies. This tells the index arithmetic, the wrap and the count saturation apart. Frames are also cut off after one and after two address bytes, to show that no request fires and that no part of the address leaks into the next frame.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RDSR = 2'd1,
    ST_PP   = 2'd2
  } eng_state_t;
endpackage

// File: rtl/spi_cmd_decode.sv
module spi_cmd_decode
  import spi_cmd_pkg::*;
#(
  parameter logic [7:0] OP_RDSR = 8'h05,
  parameter logic [7:0] OP_PP   = 8'h02
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  output eng_state_t state,
  output logic       unknown_cmd
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      unknown_cmd <= 1'b0;
    end else begin
      unknown_cmd <= 1'b0;
      if (cs_n) begin
        state <= ST_IDLE;
      end else if (rx_valid && state == ST_IDLE) begin
        if (rx_byte == OP_RDSR) begin
          state <= ST_RDSR;
        end else if (rx_byte == OP_PP) begin
          state <= ST_PP;
        end else begin
          state       <= ST_IDLE;
          unknown_cmd <= 1'b1;
        end
      end
    end
  end

  // R10: a deselected cycle always leaves the engine idle
  p_idle_after_deselect_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> state == ST_IDLE);

  // R8: unknown flag only follows an accepted byte taken in idle
  p_unknown_from_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    unknown_cmd |-> $past(rx_valid) && !$past(cs_n) && $past(state) == ST_IDLE);

endmodule

// File: rtl/spi_pp_collect.sv
module spi_pp_collect #(
  parameter int ADDR_W     = 24,
  parameter int PAGE_BYTES = 256,
  localparam int PG_W  = $clog2(PAGE_BYTES),
  localparam int CNT_W = PG_W + 1,
  localparam int NAB   = ADDR_W / 8,
  localparam int AB_W  = $clog2(NAB + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic              pp_active,
  output logic              buf_we,
  output logic [PG_W-1:0]   buf_waddr,
  output logic [7:0]        buf_wdata,
  output logic              prog_req,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [CNT_W-1:0]  prog_count
);

  logic [AB_W-1:0]   abytes;
  logic [ADDR_W-1:0] addr_acc;
  logic [ADDR_W-1:0] addr_next;
  logic [PG_W-1:0]   widx;
  logic [CNT_W-1:0]  dcnt;
  logic              addr_done;

  assign addr_next = {addr_acc[ADDR_W-9:0], rx_byte};
  assign addr_done = (abytes == AB_W'(NAB));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      abytes     <= '0;
      addr_acc   <= '0;
      widx       <= '0;
      dcnt       <= '0;
      buf_we     <= 1'b0;
      buf_waddr  <= '0;
      buf_wdata  <= '0;
      prog_req   <= 1'b0;
      prog_addr  <= '0;
      prog_count <= '0;
    end else begin
      buf_we   <= 1'b0;
      prog_req <= 1'b0;
      if (cs_n) begin
        if (pp_active && addr_done && dcnt != '0) begin
          prog_req   <= 1'b1;
          prog_addr  <= addr_acc;
          prog_count <= dcnt;
        end
        abytes   <= '0;
        addr_acc <= '0;
        widx     <= '0;
        dcnt     <= '0;
      end else if (rx_valid && pp_active) begin
        if (!addr_done) begin
          addr_acc <= addr_next;
          abytes   <= abytes + 1'b1;
          widx     <= addr_next[PG_W-1:0];
        end else begin
          buf_we    <= 1'b1;
          buf_waddr <= widx;
          buf_wdata <= rx_byte;
          widx      <= widx + 1'b1;
          if (dcnt != CNT_W'(PAGE_BYTES)) dcnt <= dcnt + 1'b1;
        end
      end
    end
  end

  // R4: buffer writes stem only from a byte taken while selected
  p_we_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> $past(rx_valid) && !$past(cs_n));

  // R6: the request follows a deselected cycle
  p_req_after_deselect_r6: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |-> $past(cs_n));

  // R5: the reported count stays within one page and is never zero
  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |-> prog_count != '0 && prog_count <= CNT_W'(PAGE_BYTES));

  // R6: request and write never share a cycle
  p_req_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |-> !buf_we);

endmodule

// File: rtl/spi_flash_cmd_engine.sv
module spi_flash_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int         ADDR_W     = 24,
  parameter int         PAGE_BYTES = 256,
  parameter logic [7:0] OP_RDSR    = 8'h05,
  parameter logic [7:0] OP_PP      = 8'h02,
  localparam int PG_W  = $clog2(PAGE_BYTES),
  localparam int CNT_W = PG_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic [7:0]        status_in,
  output logic [7:0]        miso_byte,
  output logic              unknown_cmd,
  output logic              buf_we,
  output logic [PG_W-1:0]   buf_waddr,
  output logic [7:0]        buf_wdata,
  output logic              prog_req,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [CNT_W-1:0]  prog_count
);

  eng_state_t state;

  spi_cmd_decode #(.OP_RDSR(OP_RDSR), .OP_PP(OP_PP)) u_decode (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .rx_valid    (rx_valid),
    .rx_byte     (rx_byte),
    .state       (state),
    .unknown_cmd (unknown_cmd)
  );

  spi_pp_collect #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_collect (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .rx_valid   (rx_valid),
    .rx_byte    (rx_byte),
    .pp_active  (state == ST_PP),
    .buf_we     (buf_we),
    .buf_waddr  (buf_waddr),
    .buf_wdata  (buf_wdata),
    .prog_req   (prog_req),
    .prog_addr  (prog_addr),
    .prog_count (prog_count)
  );

  always_comb begin
    miso_byte = 8'hFF;
    if (state == ST_RDSR) miso_byte = status_in;
  end

  // R9: while a write or a request is out, the response byte is idle-high
  p_miso_high_pp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_we || prog_req) |-> miso_byte == 8'hFF);

endmodule

// File: tb/spi_flash_cmd_engine_tb.sv
module spi_flash_cmd_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = 8'h00;
  logic [7:0]  status_in = 8'h00;
  logic [7:0]  miso_byte;
  logic        unknown_cmd;
  logic        buf_we;
  logic [7:0]  buf_waddr;
  logic [7:0]  buf_wdata;
  logic        prog_req;
  logic [23:0] prog_addr;
  logic [8:0]  prog_count;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  spi_flash_cmd_engine u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .status_in(status_in), .miso_byte(miso_byte),
    .unknown_cmd(unknown_cmd), .buf_we(buf_we), .buf_waddr(buf_waddr),
    .buf_wdata(buf_wdata), .prog_req(prog_req), .prog_addr(prog_addr),
    .prog_count(prog_count)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge with outputs updated
  task automatic sb(input logic [7:0] b);
    rx_valid = 1'b1;
    rx_byte  = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic sel();
    cs_n = 1'b0;
    @(negedge clk);
  endtask

  task automatic desel(input logic exp_req, input logic [23:0] ea, input int ec);
    cs_n = 1'b1;
    @(negedge clk);
    chk(prog_req == exp_req, "R6/R7 prog_req", prog_req, exp_req);
    if (exp_req) begin
      chk(prog_addr == ea, "R3 prog_addr", prog_addr, ea);
      chk(prog_count == 9'(ec), "R5/R6 prog_count", prog_count, ec);
    end
    @(negedge clk);
    chk(prog_req == 1'b0, "R6 single pulse", prog_req, 0);
  endtask

  task automatic pp_run(input logic [23:0] a, input int n);
    int ec;
    sel();
    sb(8'h02);
    sb(a[23:16]);
    sb(a[15:8]);
    sb(a[7:0]);
    chk(buf_we == 1'b0, "R4 no write on address", buf_we, 0);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      logic [7:0] ew;
      d  = 8'((i * 7 + a[7:0] + 3) & 255);
      ew = 8'((a[7:0] + i) % 256);
      sb(d);
      chk(buf_we == 1'b1, "R4 write strobe", buf_we, 1);
      chk(buf_waddr == ew, "R4/R5 write index", buf_waddr, ew);
      chk(buf_wdata == d, "R4 write data", buf_wdata, d);
      chk(miso_byte == 8'hFF, "R9 miso in program", miso_byte, 8'hFF);
    end
    ec = (n > 256) ? 256 : n;
    desel(n > 0, a, ec);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    chk(buf_we == 1'b0, "R1 buf_we", buf_we, 0);
    chk(prog_req == 1'b0, "R1 prog_req", prog_req, 0);
    chk(unknown_cmd == 1'b0, "R1 unknown_cmd", unknown_cmd, 0);
    chk(miso_byte == 8'hFF, "R1 miso", miso_byte, 8'hFF);
    rst_n = 1'b1;
    @(negedge clk);

    // R8/R2/R9 sweep every opcode
    for (int op = 0; op < 256; op++) begin
      logic is_known;
      is_known = (op == 8'h05) || (op == 8'h02);
      status_in = 8'(op ^ 8'h5A);
      sel();
      chk(miso_byte == 8'hFF, "R9 miso idle", miso_byte, 8'hFF);
      sb(8'(op));
      chk(unknown_cmd == !is_known, "R8 unknown flag", unknown_cmd, !is_known);
      if (op == 8'h05)
        chk(miso_byte == status_in, "R2 status after opcode", miso_byte, status_in);
      else
        chk(miso_byte == 8'hFF, "R9 miso non-status", miso_byte, 8'hFF);
      desel(1'b0, 24'h0, 0);
      chk(miso_byte == 8'hFF, "R10 idle after deselect", miso_byte, 8'hFF);
    end

    // R2 repeated status reads with a changing status
    sel();
    sb(8'h05);
    for (int k = 0; k < 6; k++) begin
      status_in = 8'(k * 37 + 1);
      sb(8'h00);
      chk(miso_byte == status_in, "R2 repeated status", miso_byte, status_in);
      chk(unknown_cmd == 1'b0, "R2 no unknown", unknown_cmd, 0);
    end
    desel(1'b0, 24'h0, 0);

    // R8 unknown then status in the same frame
    status_in = 8'hC3;
    sel();
    sb(8'h9F);
    chk(unknown_cmd == 1'b1, "R8 unknown", unknown_cmd, 1);
    sb(8'h05);
    chk(miso_byte == 8'hC3, "R8 re-decode", miso_byte, 8'hC3);
    desel(1'b0, 24'h0, 0);

    // R10 strobes while deselected are ignored
    sb(8'h05);
    chk(miso_byte == 8'hFF, "R10 ignored status opcode", miso_byte, 8'hFF);
    sb(8'h02);
    sb(8'h11);
    sb(8'h22);
    sb(8'h33);
    sb(8'h44);
    chk(buf_we == 1'b0, "R10 ignored data", buf_we, 0);
    chk(unknown_cmd == 1'b0, "R10 ignored unknown", unknown_cmd, 0);

    // R7 aborts during address phase and with no data
    sel(); sb(8'h02); sb(8'hAB); desel(1'b0, 24'h0, 0);
    sel(); sb(8'h02); sb(8'hAB); sb(8'hCD); desel(1'b0, 24'h0, 0);
    pp_run(24'h123456, 0);
    // R7 fresh address after aborts
    pp_run(24'h0A0B0C, 1);

    // R3 R4 R5 R6 lengths and offsets
    pp_run(24'hFFFFFF, 2);
    pp_run(24'h000001, 255);
    pp_run(24'h345600, 256);
    pp_run(24'h7700F0, 257);
    pp_run(24'h8000A5, 300);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule